// File: doc/BRIEF.md
# Dithered Phase Accumulator Oscillator

This block is a numerically controlled oscillator core with a wide frequency word that it does not add in one piece. The word is `FTW_W` bits wide and has two parts: an upper part of `ACC_W = FTW_W - FRAC_W` bits and a lower part of `FRAC_W` bits. On every clock the upper part is added to an `ACC_W`-bit phase accumulator that wraps without overflow. The lower part sets the duty cycle of a dither pattern. For that many cycles in each frame of `2^FRAC_W` cycles, the accumulator adds one more than the upper part. Over a full frame the phase therefore advances by exactly the amount a full-width `FTW_W`-bit accumulator would produce, without the wide adder.

A new word arrives over a valid/ready port. It is held in a shadow register and takes effect as a whole at the next frame boundary, so the two parts never disagree. While a word waits in the shadow register, `ftw_ready` is low. An offered word is taken only on a cycle with `ftw_valid` and `ftw_ready` both high. While `ftw_ready` is low the offer is not taken, and the source must hold it until `ftw_ready` returns. Output phase is adjusted by a one-shot strobe that adds a fractional-cycle offset into the accumulator. For a shift of d degrees the offset is d/360 of 2^`ACC_W`. The MSB of the phase is the square-wave output.

Top module: `nco_dither_core`

## Requirements
- R1: Synchronous reset clears the phase, the dither counter and the active and shadow words. After reset `phase_o` is 0, `square_o` is 0 and `ftw_ready` is 1. The phase then stays at 0 until a word is applied.
- R2: A word is taken only when `ftw_valid` and `ftw_ready` are both high. On the next cycle `ftw_ready` drops, and it stays low until the word is applied. Offers made while it is low are not taken and never take effect.
- R3: A held word takes effect on the clock edge where the dither counter wraps from all ones to 0. `ftw_ready` rises on that same edge.
- R4: Bits [FTW_W-1:FRAC_W] of the word are the base step H and bits [FRAC_W-1:0] are the dither count L. The counter counts from 0 after the wrap. In a frame, cycles with counter < L add H+1 and the others add H, so the larger steps lead the frame.
- R5: Over the `2^FRAC_W` cycles that follow a wrap edge, the total phase advance equals `2^FRAC_W*H + L` modulo `2^ACC_W`.
- R6: On a cycle with `phase_adj_en` high, `phase_adj` is added once to the phase on top of that cycle's step. The next cycle carries no offset.
- R7: `square_o` equals bit `ACC_W-1` of `phase_o` on every cycle.
- R8: The phase wraps modulo `2^ACC_W`. A step that passes the top of the range lands at the sum minus `2^ACC_W`.
- R9: When the offset strobe falls on the wrap cycle, that edge adds the outgoing word's step plus the offset. The next cycle uses the new word.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| ftw_valid | input | 1 | A frequency word is offered |
| ftw_ready | output | 1 | Shadow register free; an offer is taken |
| ftw_data | input | FTW_W | Frequency word: base step over dither count |
| phase_adj_en | input | 1 | One-shot strobe to add the phase offset |
| phase_adj | input | ACC_W | Phase offset as a fraction of a cycle |
| phase_o | output | ACC_W | Accumulator phase |
| square_o | output | 1 | Accumulator MSB |

## Verification
Two events can fall on the same clock edge: the phase-offset strobe and the frame wrap that installs a held word. The bench tracks the frame position by counting edges since reset. It raises the strobe on exactly the cycle before the wrap, while a new word is held. It then checks three things: that edge adds the outgoing base step plus the offset, `ftw_ready` rises on it, and the following step is the new word's first, larger step.

// File: rtl/nco_pkg.sv
package nco_pkg;
  localparam int NCO_FTW_W  = 64;
  localparam int NCO_FRAC_W = 16;

  typedef enum logic {
    SH_EMPTY   = 1'b0,
    SH_WAITING = 1'b1
  } shadow_st_e;
endpackage

// File: rtl/nco_dither_pwm.sv
module nco_dither_pwm #(
  parameter int FRAC_W = 16
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [FRAC_W-1:0] duty,
  output logic              wrap,
  output logic              bump
);
  logic [FRAC_W-1:0] cnt;

  always_ff @(posedge clk) begin
    if (rst) cnt <= '0;
    else     cnt <= cnt + 1'b1;
  end

  // frame ends when the counter is all ones
  assign wrap = &cnt;
  // larger step for the first 'duty' cycles of each frame
  assign bump = (cnt < duty);
endmodule

// File: rtl/nco_tune_shadow.sv
module nco_tune_shadow
  import nco_pkg::*;
#(
  parameter int FTW_W  = 64,
  parameter int FRAC_W = 16,
  localparam int HI_W  = FTW_W - FRAC_W
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              in_valid,
  output logic              in_ready,
  input  logic [FTW_W-1:0]  in_word,
  input  logic              wrap,
  output logic [HI_W-1:0]   act_hi,
  output logic [FRAC_W-1:0] act_lo
);
  shadow_st_e       st;
  logic [FTW_W-1:0] held;
  logic             take;

  assign in_ready = (st == SH_EMPTY);
  assign take     = in_valid && in_ready;

  always_ff @(posedge clk) begin
    if (rst) begin
      st     <= SH_EMPTY;
      held   <= '0;
      act_hi <= '0;
      act_lo <= '0;
    end else begin
      if (take) begin
        held <= in_word;
        st   <= SH_WAITING;
      end else if (wrap && st == SH_WAITING) begin
        act_hi <= held[FTW_W-1:FRAC_W];
        act_lo <= held[FRAC_W-1:0];
        st     <= SH_EMPTY;
      end
    end
  end
endmodule

// File: rtl/nco_phase_accum.sv
module nco_phase_accum #(
  parameter int ACC_W = 48
) (
  input  logic             clk,
  input  logic             rst,
  input  logic [ACC_W-1:0] step_base,
  input  logic             bump,
  input  logic             adj_en,
  input  logic [ACC_W-1:0] adj,
  output logic [ACC_W-1:0] phase
);
  logic [ACC_W-1:0] step;
  logic [ACC_W-1:0] offs;

  assign step = step_base + ACC_W'(bump);
  assign offs = adj_en ? adj : '0;

  always_ff @(posedge clk) begin
    if (rst) phase <= '0;
    else     phase <= phase + step + offs;
  end
endmodule

// File: rtl/nco_dither_core.sv
module nco_dither_core
  import nco_pkg::*;
#(
  parameter int FTW_W  = NCO_FTW_W,
  parameter int FRAC_W = NCO_FRAC_W,
  localparam int ACC_W = FTW_W - FRAC_W
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             ftw_valid,
  output logic             ftw_ready,
  input  logic [FTW_W-1:0] ftw_data,
  input  logic             phase_adj_en,
  input  logic [ACC_W-1:0] phase_adj,
  output logic [ACC_W-1:0] phase_o,
  output logic             square_o
);
  logic [ACC_W-1:0]  act_hi;
  logic [FRAC_W-1:0] act_lo;
  logic              wrap;
  logic              bump;

  nco_tune_shadow #(.FTW_W(FTW_W), .FRAC_W(FRAC_W)) u_shadow (
    .clk      (clk),
    .rst      (rst),
    .in_valid (ftw_valid),
    .in_ready (ftw_ready),
    .in_word  (ftw_data),
    .wrap     (wrap),
    .act_hi   (act_hi),
    .act_lo   (act_lo)
  );

  nco_dither_pwm #(.FRAC_W(FRAC_W)) u_pwm (
    .clk  (clk),
    .rst  (rst),
    .duty (act_lo),
    .wrap (wrap),
    .bump (bump)
  );

  nco_phase_accum #(.ACC_W(ACC_W)) u_acc (
    .clk       (clk),
    .rst       (rst),
    .step_base (act_hi),
    .bump      (bump),
    .adj_en    (phase_adj_en),
    .adj       (phase_adj),
    .phase     (phase_o)
  );

  assign square_o = phase_o[ACC_W-1];
endmodule

// File: rtl/nco_dither_core_chk.sv
module nco_dither_core_chk #(
  parameter int ACC_W  = 48,
  parameter int FRAC_W = 16
) (
  input logic              clk,
  input logic              rst,
  input logic              ftw_valid,
  input logic              ftw_ready,
  input logic              phase_adj_en,
  input logic [ACC_W-1:0]  phase_adj,
  input logic [ACC_W-1:0]  phase_o,
  input logic [ACC_W-1:0]  act_hi,
  input logic [FRAC_W-1:0] act_lo,
  input logic              bump,
  input logic              wrap
);
  logic [ACC_W-1:0] prev_phase;
  logic [ACC_W-1:0] prev_hi;
  logic [ACC_W-1:0] prev_adj;
  logic             prev_bump;
  logic             prev_en;
  logic             prev_rst;
  logic [ACC_W-1:0] adv;

  always_ff @(posedge clk) begin
    prev_phase <= phase_o;
    prev_hi    <= act_hi;
    prev_adj   <= phase_adj;
    prev_bump  <= bump;
    prev_en    <= phase_adj_en;
    prev_rst   <= rst;
  end

  assign adv = phase_o - prev_phase;

  // R1: reset empties phase and shadow
  a_r1_reset_clears: assert property (@(posedge clk)
    rst |=> (phase_o == '0) && ftw_ready);

  // R2: an accepted word blocks further offers
  a_r2_ready_drops: assert property (@(posedge clk) disable iff (rst)
    (ftw_valid && ftw_ready) |=> !ftw_ready);

  // R3: active word changes only at the frame wrap
  a_r3_word_at_wrap: assert property (@(posedge clk) disable iff (rst)
    !wrap |=> ($stable(act_hi) && $stable(act_lo)));

  // R4: dither steps begin only at the start of a frame
  a_r4_bump_leads: assert property (@(posedge clk) disable iff (rst)
    $rose(bump) |-> $past(wrap));

  // R4 / R6: each advance is the base step, dither bit and one-shot offset
  a_r6_advance: assert property (@(posedge clk) disable iff (rst)
    !prev_rst |-> (adv == prev_hi + ACC_W'(prev_bump) + (prev_en ? prev_adj : '0)));
endmodule

bind nco_dither_core nco_dither_core_chk #(.ACC_W(ACC_W), .FRAC_W(FRAC_W)) u_chk (
  .clk          (clk),
  .rst          (rst),
  .ftw_valid    (ftw_valid),
  .ftw_ready    (ftw_ready),
  .phase_adj_en (phase_adj_en),
  .phase_adj    (phase_adj),
  .phase_o      (phase_o),
  .act_hi       (act_hi),
  .act_lo       (act_lo),
  .bump         (bump),
  .wrap         (wrap)
);

// File: tb/sim_nco_dither_core.sv
module sim_nco_dither_core;
  localparam int CLK_PERIOD = 10;
  localparam int FTW_W  = 28;
  localparam int FRAC_W = 8;
  localparam int ACC_W  = FTW_W - FRAC_W;
  localparam int N      = 1 << FRAC_W;
  localparam int NVEC   = 6;
  // {base step H[19:0], dither count L[7:0]}
  localparam logic [FTW_W-1:0] VEC [NVEC] = '{
    28'h0000100, 28'h0000101, 28'h12345FF,
    28'h0000001, 28'hFFFFF80, 28'h8000040
  };

  logic             clk = 1'b0;
  logic             rst = 1'b1;
  logic             ftw_valid = 1'b0;
  logic             ftw_ready;
  logic [FTW_W-1:0] ftw_data = '0;
  logic             phase_adj_en = 1'b0;
  logic [ACC_W-1:0] phase_adj = '0;
  logic [ACC_W-1:0] phase_o;
  logic             square_o;

  int checks = 0;
  int fails  = 0;
  int edges  = 0;
  bit done   = 1'b0;

  nco_dither_core #(.FTW_W(FTW_W), .FRAC_W(FRAC_W)) u0 (
    .clk(clk), .rst(rst), .ftw_valid(ftw_valid), .ftw_ready(ftw_ready),
    .ftw_data(ftw_data), .phase_adj_en(phase_adj_en), .phase_adj(phase_adj),
    .phase_o(phase_o), .square_o(square_o)
  );

  always #(CLK_PERIOD/2) clk = ~clk;

  // bench's own frame position: edges since reset released
  always @(posedge clk) begin
    if (rst) edges <= 0;
    else     edges <= edges + 1;
  end

  task automatic chk(input bit ok, input string req, input string what,
                     input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
    end
  endtask

  task automatic finish_up();
    if (!done) begin
      done = 1'b1;
      $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
      $finish;
    end
  endtask

  task automatic load_word(input logic [FTW_W-1:0] w);
    while (!ftw_ready) @(negedge clk);
    ftw_valid = 1'b1;
    ftw_data  = w;
    @(negedge clk);
    ftw_valid = 1'b0;
    chk(!ftw_ready, "R2", "ready after accept", 64'(ftw_ready), 64'd0);
  endtask

  task automatic wait_apply();
    while (!ftw_ready) @(negedge clk);
    chk((edges % N) == 0, "R3", "word applied off wrap", 64'(edges % N), 64'd0);
  endtask

  task automatic run_window(input logic [FTW_W-1:0] w, input string tag);
    logic [ACC_W-1:0]  hi = w[FTW_W-1:FRAC_W];
    logic [FRAC_W-1:0] lo = w[FRAC_W-1:0];
    logic [ACC_W-1:0]  p0 = phase_o;
    logic [ACC_W-1:0]  prev = phase_o;
    logic [ACC_W-1:0]  step;
    logic [ACC_W-1:0]  exp_step;
    logic [ACC_W-1:0]  total;
    logic [ACC_W-1:0]  exp_total;
    int bad_step = 0;
    int bad_sq = 0;
    for (int k = 0; k < N; k++) begin
      @(negedge clk);
      step     = phase_o - prev;
      exp_step = hi + ((k < int'(lo)) ? 20'd1 : 20'd0);
      if (step != exp_step) bad_step++;
      if (square_o != phase_o[ACC_W-1]) bad_sq++;
      prev = phase_o;
    end
    total     = phase_o - p0;
    exp_total = (hi << FRAC_W) + ACC_W'(lo);
    chk(bad_step == 0, "R4", {tag, " step pattern"}, 64'(bad_step), 64'd0);
    chk(total == exp_total, "R5", {tag, " frame advance"}, 64'(total), 64'(exp_total));
    chk(bad_sq == 0, "R7", {tag, " square vs MSB"}, 64'(bad_sq), 64'd0);
  endtask

  initial begin
    #(CLK_PERIOD * 150000);
    fails++;
    $display("FAIL watchdog: actual timeout expected finish");
    finish_up();
  end

  initial begin
    logic [ACC_W-1:0] p;
    logic [ACC_W-1:0] hi;
    logic [FRAC_W-1:0] lo;
    int c;

    // R1: reset state
    repeat (3) @(negedge clk);
    rst = 1'b0;
    chk(phase_o == 0, "R1", "phase after reset", 64'(phase_o), 64'd0);
    chk(square_o == 0, "R1", "square after reset", 64'(square_o), 64'd0);
    chk(ftw_ready == 1, "R1", "ready after reset", 64'(ftw_ready), 64'd1);
    repeat (5) @(negedge clk);
    chk(phase_o == 0, "R1", "phase idle with cleared word", 64'(phase_o), 64'd0);

    // table of words, one frame each
    for (int i = 0; i < NVEC; i++) begin
      load_word(VEC[i]);
      if (i == 2) begin
        // R2: offers while held are refused
        ftw_valid = 1'b1;
        ftw_data  = 28'h0ABCD11;
        c = 0;
        for (int j = 0; j < 4; j++) begin
          @(negedge clk);
          if (ftw_ready) c++;
        end
        ftw_valid = 1'b0;
        chk(c == 0, "R2", "ready while held", 64'(c), 64'd0);
      end
      wait_apply();
      run_window(VEC[i], (i == 4) ? "R8 wrap" : "table");
      if (i == 2) begin
        chk(ftw_ready == 1, "R2", "no refused word pending", 64'(ftw_ready), 64'd1);
        run_window(VEC[i], "R2 refused offer");
      end
    end

    // R6: one-shot offset mid-frame (word is VEC[5])
    hi = VEC[NVEC-1][FTW_W-1:FRAC_W];
    lo = VEC[NVEC-1][FRAC_W-1:0];
    repeat (10) @(negedge clk);
    c = edges % N;
    p = phase_o;
    phase_adj_en = 1'b1;
    phase_adj    = 20'h40000;
    @(negedge clk);
    phase_adj_en = 1'b0;
    chk(phase_o - p == hi + ((c < int'(lo)) ? 20'd1 : 20'd0) + 20'h40000, "R6",
        "offset cycle step", 64'(phase_o - p),
        64'(hi + ((c < int'(lo)) ? 20'd1 : 20'd0) + 20'h40000));
    c = edges % N;
    p = phase_o;
    @(negedge clk);
    chk(phase_o - p == hi + ((c < int'(lo)) ? 20'd1 : 20'd0), "R6",
        "no offset next cycle", 64'(phase_o - p),
        64'(hi + ((c < int'(lo)) ? 20'd1 : 20'd0)));

    // R9: offset strobe on the wrap cycle with a new word held
    load_word(28'h0003205);
    while ((edges % N) != N - 1) @(negedge clk);
    p = phase_o;
    phase_adj_en = 1'b1;
    phase_adj    = 20'h00777;
    @(negedge clk);
    phase_adj_en = 1'b0;
    chk(phase_o - p == hi + 20'h00777, "R9", "wrap edge step",
        64'(phase_o - p), 64'(hi + 20'h00777));
    chk(ftw_ready == 1, "R9", "ready on wrap edge", 64'(ftw_ready), 64'd1);
    p = phase_o;
    @(negedge clk);
    chk(phase_o - p == 20'h00033, "R9", "first step of new word",
        64'(phase_o - p), 64'h33);

    // R1: reset during operation
    rst = 1'b1;
    @(negedge clk);
    rst = 1'b0;
    chk(phase_o == 0, "R1", "phase after mid-run reset", 64'(phase_o), 64'd0);
    repeat (4) @(negedge clk);
    chk(phase_o == 0, "R1", "word cleared by reset", 64'(phase_o), 64'd0);
    chk(ftw_ready == 1, "R1", "ready after mid-run reset", 64'(ftw_ready), 64'd1);

    finish_up();
  end
endmodule